// File: doc/BRIEF.md
# DMA-Ready Coprocessor Branch Condition Unit

This block resolves coprocessor-0 conditional branches whose condition is derived from two DMA controller registers: a channel status register and a channel priority-control register. The condition is met when every channel selected in the priority-control register's low ten bits also has its status bit set. A priority-control value that selects no channels therefore always satisfies the condition.

The branch instruction word supplies the variant (bits 17:16) and a 16-bit word offset (bits 15:0). Four variants exist: branch-on-false, branch-on-true and the likely forms of each. The block reports whether the branch is taken, whether the delay-slot instruction must be nullified, and registers the program counter that follows the branch whenever a branch is presented with `br_valid` high. The condition, taken flag and nullify signal are combinational; only the next PC is registered. Reset is asynchronous and active low, with a synchronous release inside the block.

Top module: `dcb_branch_unit`

## Requirements
- R1: `cond_met` is 1 exactly when, over bits 9:0, every bit set in `dma_pcr` is also set in `dma_stat` (equivalently (stat & pcr) == pcr on those bits).
- R2: Bits 15:10 of `dma_stat` and `dma_pcr` have no effect on `cond_met`.
- R3: When bits 9:0 of `dma_pcr` are all zero, `cond_met` is 1 whatever `dma_stat` holds.
- R4: The variant is `br_insn[17:16]`: 00 branch-on-false, 01 branch-on-true, 10 branch-on-false-likely, 11 branch-on-true-likely; `br_taken` is 1 exactly when `cond_met` equals bit 16 of the instruction.
- R5: The likely variants (bit 17 set) use the same taken rule as their non-likely counterparts.
- R6: `slot_nullify` is 1 only for a likely variant that is not taken; non-likely variants never nullify the delay slot.
- R7: The branch target is `br_pc + 4 + (sign-extended br_insn[15:0] << 2)`, modulo 2^32.
- R8: On a rising clock edge with `br_valid` high, `next_pc_q` takes the target when taken, `br_pc + 8` when a likely variant is not taken, and `br_pc + 4` when a non-likely variant is not taken.
- R9: On a rising clock edge with `br_valid` low, `next_pc_q` keeps its value.
- R10: After reset `next_pc_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is presented this cycle; enables the next-PC register |
| dma_stat | input | 16 | DMA channel status register value |
| dma_pcr | input | 16 | DMA channel priority-control register value |
| br_insn | input | 32 | Branch instruction word (variant in 17:16, offset in 15:0) |
| br_pc | input | 32 | Address of the branch instruction |
| cond_met | output | 1 | Channel condition result |
| br_taken | output | 1 | Branch is taken |
| slot_nullify | output | 1 | Delay-slot instruction must be discarded |
| next_pc_q | output | 32 | Registered PC following the branch |

## Verification
The bench walks every low-ten-bit priority-control value against a full-match status, a status missing one selected channel and an inverted status, so a design that ORed instead of ANDed the channels, or tested "any channel" rather than "all selected channels", reports a wrong condition; the empty mask case catches a design that reports false when nothing is selected. Upper register bits are toggled to catch a mask that is too wide. Every variant is crossed with both condition values, negative, zero and extreme offsets and a PC near the top of the address space, so swapped variant decoding, a nullify on a non-likely branch, a missing sign extension or an unskipped delay slot shows up as a wrong next PC or flag. Cycles with `br_valid` low check that the registered PC does not move.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  typedef enum logic [1:0] {
    BK_ON_FALSE      = 2'b00,
    BK_ON_TRUE       = 2'b01,
    BK_ON_FALSE_LIKE = 2'b10,
    BK_ON_TRUE_LIKE  = 2'b11
  } br_kind_e;

  typedef struct packed {
    logic taken;
    logic nullify;
    logic likely;
  } br_res_t;

endpackage

// File: rtl/dcb_cond_eval.sv
module dcb_cond_eval #(
  parameter int REG_W  = 16,
  parameter int CHAN_W = 10
) (
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] pcr,
  output logic             cond
);

  localparam int HI_W = REG_W - CHAN_W;

  logic [CHAN_W-1:0] chan_ok;

  // One "satisfied" bit per channel: either not selected or has status set.
  generate
    for (genvar g = 0; g < CHAN_W; g++) begin : g_chan
      assign chan_ok[g] = stat[g] | ~pcr[g];
    end
  endgenerate

  assign cond = &chan_ok;

  generate
    if (HI_W > 0) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^{stat[REG_W-1:CHAN_W], pcr[REG_W-1:CHAN_W]};
    end
  endgenerate

endmodule

// File: rtl/dcb_variant_decode.sv
module dcb_variant_decode
  import dcb_pkg::*;
(
  input  br_kind_e kind,
  input  logic     cond,
  output br_res_t  res
);

  always_comb begin
    res = '0;
    unique case (kind)
      BK_ON_FALSE: begin
        res.taken  = ~cond;
        res.likely = 1'b0;
      end
      BK_ON_TRUE: begin
        res.taken  = cond;
        res.likely = 1'b0;
      end
      BK_ON_FALSE_LIKE: begin
        res.taken  = ~cond;
        res.likely = 1'b1;
      end
      BK_ON_TRUE_LIKE: begin
        res.taken  = cond;
        res.likely = 1'b1;
      end
      default: res = '0;
    endcase
    res.nullify = res.likely & ~res.taken;
  end

endmodule

// File: rtl/dcb_pc_calc.sv
module dcb_pc_calc #(
  parameter int PC_W  = 32,
  parameter int OFS_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  target,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  skip_pc
);

  localparam int EXT_W = PC_W - OFS_W - 2;

  logic [PC_W-1:0] byte_ofs;

  assign byte_ofs = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
  assign seq_pc   = pc + PC_W'(4);
  assign skip_pc  = pc + PC_W'(8);
  assign target   = seq_pc + byte_ofs;

endmodule

// File: rtl/dcb_branch_unit.sv
module dcb_branch_unit
  import dcb_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CHAN_W   = 10,
  parameter int INSN_W   = 32,
  parameter int PC_W     = 32,
  parameter int OFS_W    = 16,
  parameter int KIND_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [REG_W-1:0]  dma_stat,
  input  logic [REG_W-1:0]  dma_pcr,
  input  logic [INSN_W-1:0] br_insn,
  input  logic [PC_W-1:0]   br_pc,
  output logic              cond_met,
  output logic              br_taken,
  output logic              slot_nullify,
  output logic [PC_W-1:0]   next_pc_q
);

  localparam int KIND_MSB = KIND_LSB + 1;

  // Reset synchronizer: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Field extraction
  br_kind_e         kind;
  logic [OFS_W-1:0] ofs;
  logic             unused_insn;

  assign kind        = br_kind_e'(br_insn[KIND_MSB:KIND_LSB]);
  assign ofs         = br_insn[OFS_W-1:0];
  assign unused_insn = ^{br_insn[INSN_W-1:KIND_MSB+1], br_insn[KIND_LSB-1:OFS_W]} |
                       (KIND_LSB == OFS_W);

  // Condition and variant resolution
  br_res_t         res;
  logic [PC_W-1:0] target, seq_pc, skip_pc;

  dcb_cond_eval #(.REG_W(REG_W), .CHAN_W(CHAN_W)) u_cond (
    .stat (dma_stat),
    .pcr  (dma_pcr),
    .cond (cond_met)
  );

  dcb_variant_decode u_dec (
    .kind (kind),
    .cond (cond_met),
    .res  (res)
  );

  dcb_pc_calc #(.PC_W(PC_W), .OFS_W(OFS_W)) u_pc (
    .pc      (br_pc),
    .ofs     (ofs),
    .target  (target),
    .seq_pc  (seq_pc),
    .skip_pc (skip_pc)
  );

  assign br_taken     = res.taken;
  assign slot_nullify = res.nullify;

  // Next-PC stage: next-state process
  logic [PC_W-1:0] resolved_pc;
  logic [PC_W-1:0] next_pc_d;
  logic            next_pc_en;

  always_comb begin
    if (res.taken)        resolved_pc = target;
    else if (res.nullify) resolved_pc = skip_pc;
    else                  resolved_pc = seq_pc;
    next_pc_en = br_valid;
    next_pc_d  = next_pc_en ? resolved_pc : next_pc_q;
  end

  // Next-PC stage: register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) next_pc_q <= '0;
    else            next_pc_q <= next_pc_d;
  end

endmodule

// File: rtl/dcb_branch_unit_chk.sv
module dcb_branch_unit_chk #(
  parameter int REG_W  = 16,
  parameter int CHAN_W = 10,
  parameter int INSN_W = 32,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [REG_W-1:0]  dma_pcr,
  input logic [INSN_W-1:0] br_insn,
  input logic [PC_W-1:0]   br_pc,
  input logic              cond_met,
  input logic              br_taken,
  input logic              slot_nullify,
  input logic [PC_W-1:0]   next_pc_q
);

  logic unused_chk;
  assign unused_chk = ^{br_insn[INSN_W-1:18], br_insn[15:0]};

  // R3: empty channel selection always satisfies the condition
  assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pcr[CHAN_W-1:0] == '0) |-> cond_met);

  // R6: a nullified slot never accompanies a taken branch
  assert_null_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_nullify |-> !br_taken);

  // R6: non-likely variants never nullify
  assert_plain_no_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !br_insn[17] |-> !slot_nullify);

  // R4: taken follows the variant's sense bit against the condition
  assert_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (cond_met == br_insn[16]));

  // R8: a nullified likely branch skips over the delay slot
  assert_skip_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && slot_nullify) |=> (next_pc_q == $past(br_pc) + PC_W'(8)));

  // R8: a plain not-taken branch continues sequentially
  assert_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_taken && !br_insn[17]) |=> (next_pc_q == $past(br_pc) + PC_W'(4)));

  // R9: register holds without a presented branch
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(next_pc_q));

endmodule

bind dcb_branch_unit dcb_branch_unit_chk #(
  .REG_W(REG_W), .CHAN_W(CHAN_W), .INSN_W(INSN_W), .PC_W(PC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .br_valid     (br_valid),
  .dma_pcr      (dma_pcr),
  .br_insn      (br_insn),
  .br_pc        (br_pc),
  .cond_met     (cond_met),
  .br_taken     (br_taken),
  .slot_nullify (slot_nullify),
  .next_pc_q    (next_pc_q)
);

// File: tb/sim_dcb_branch_unit.sv
`timescale 1ns/1ps
module sim_dcb_branch_unit;

  logic        clk;
  logic        rst_n;
  logic        br_valid;
  logic [15:0] dma_stat;
  logic [15:0] dma_pcr;
  logic [31:0] br_insn;
  logic [31:0] br_pc;
  logic        cond_met;
  logic        br_taken;
  logic        slot_nullify;
  logic [31:0] next_pc_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  dcb_branch_unit u0 (
    .clk (clk), .rst_n (rst_n), .br_valid (br_valid),
    .dma_stat (dma_stat), .dma_pcr (dma_pcr), .br_insn (br_insn), .br_pc (br_pc),
    .cond_met (cond_met), .br_taken (br_taken), .slot_nullify (slot_nullify),
    .next_pc_q (next_pc_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_ref(input logic [15:0] s, input logic [15:0] p);
    return ((s & p & 16'h03FF) == (p & 16'h03FF));
  endfunction

  initial begin
    #900000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs_pc [3];
    logic [15:0] offs    [5];
    offs_pc = '{32'h0000_1000, 32'hFFFF_FFF8, 32'h8000_0000};
    offs    = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};

    rst_n = 1'b0; br_valid = 1'b0; dma_stat = '0; dma_pcr = '0;
    br_insn = '0; br_pc = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset next_pc", next_pc_q, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 after release", next_pc_q, 32'h0);

    // Condition sweep over every low-ten-bit mask
    for (int p = 0; p < 1024; p++) begin
      logic [15:0] pv, sv;
      pv = 16'(p) | {6'(p * 37), 10'h0};
      sv = pv;
      dma_pcr = pv; dma_stat = sv; #1;
      chk("R1 full match", 32'(cond_met), 32'(cond_ref(sv, pv)));
      if (p != 0) begin
        sv = pv & ~(pv & (~pv + 16'h1)) & 16'h03FF;
        dma_stat = sv; #1;
        chk("R1 one channel missing", 32'(cond_met), 32'h0);
      end
      sv = ~pv;
      dma_stat = sv; #1;
      chk("R1 inverted status", 32'(cond_met), 32'(cond_ref(sv, pv)));
      if (p == 0) chk("R3 empty mask", 32'(cond_met), 32'h1);
      dma_pcr = {6'h3F, pv[9:0]}; dma_stat = {6'h00, sv[9:0]}; #1;
      chk("R2 upper bits ignored", 32'(cond_met), 32'(cond_ref(sv, pv)));
    end

    // Branch variant sweep
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 2; c++) begin
        for (int o = 0; o < 5; o++) begin
          for (int q = 0; q < 3; q++) begin
            logic        tk, nl;
            logic [31:0] tgt, nx, ext;
            @(negedge clk);
            dma_pcr  = 16'h0003;
            dma_stat = (c == 1) ? 16'hFC03 : 16'h0001;
            br_insn  = {14'h2A5A, 2'(k), offs[o]};
            br_pc    = offs_pc[q];
            br_valid = 1'b1;
            #1;
            tk  = (1'(c) == 1'(k));
            nl  = (k >= 2) && !tk;
            ext = {{14{offs[o][15]}}, offs[o], 2'b00};
            tgt = br_pc + 32'd4 + ext;
            nx  = tk ? tgt : (nl ? br_pc + 32'd8 : br_pc + 32'd4);
            if (k < 2) chk("R4 taken non-likely", 32'(br_taken), 32'(tk));
            else       chk("R5 taken likely", 32'(br_taken), 32'(tk));
            chk("R6 nullify", 32'(slot_nullify), 32'(nl));
            @(posedge clk); #1;
            if (tk) chk("R7 target", next_pc_q, nx);
            else    chk("R8 not-taken next pc", next_pc_q, nx);
          end
        end
      end
    end

    // Hold when no branch is presented
    for (int h = 0; h < 8; h++) begin
      logic [31:0] held;
      @(negedge clk);
      held     = next_pc_q;
      br_valid = 1'b0;
      br_pc    = 32'h0100_0000 * 32'(h);
      br_insn  = {14'h0, 2'(h), 16'(h * 1000)};
      dma_stat = 16'(h * 77);
      @(posedge clk); #1;
      chk("R9 hold", next_pc_q, held);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule